// File: doc/BRIEF.md
# Potentiometer Wiper Counter Bank

This block keeps the wiper position of a bank of digitally controlled potentiometer channels. Each channel owns a volatile counter whose value selects one of the taps of its resistor string. Code 0 puts the wiper at the low terminal and the all-ones code puts it at the high terminal. The tap decoder and the resistor array sit outside this block. The serial command decoder in front of it turns host commands into the strobes on its ports.

A counter takes a new value from one of four places. A power-up strobe copies every channel's default stored setting. A host write loads one chosen channel at once. A single transfer copies one stored register into one channel. A global transfer copies a stored register into every channel. Both transfers reach the output only after a settling delay, counted in clock ticks. After the stepping command, the decoder turns each serial clock pulse into a step strobe. The serial data bit gives the direction, and the chosen counter moves one tap per pulse. Stepping stops at both ends of the range and never wraps.

Top module: `wiper_bank`

## Requirements
- R1: While reset is asserted, and after it is released until the first power-up strobe, every wiper output reads 0.
- R2: A power-up strobe sampled at a clock edge loads every channel k from bits [WIDTH*k+WIDTH-1 : WIDTH*k] of the power-up data input, visible right after that edge.
- R3: A host write strobe loads host data into the channel whose binary index is on the host select input, visible right after the sampling edge. Channel k always appears on wiper bits [WIDTH*k+WIDTH-1 : WIDTH*k], and the other channels keep their values.
- R4: A single transfer strobe leaves the selected channel unchanged for DELAY_TICKS-1 further edges. The transfer data appears on that channel right after the DELAY_TICKS-th edge after the sampling edge.
- R5: A global transfer strobe loads every channel from its own slice of the global data input, following the same delay as R4.
- R6: A step strobe with the up bit at 1 raises the selected channel by one. With the up bit at 0 it lowers it by one. No other channel changes, and with no strobe no wiper changes.
- R7: A step up at the all-ones code and a step down at code 0 leave the value unchanged.
- R8: When a load and a step for the same channel meet in one cycle, the load value is taken and the step is dropped. Priority from highest to lowest: power-up, host write, transfer, step.
- R9: A host write or power-up strobe cancels a transfer still waiting on the same channel, so the written value stays after the delay runs out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwrup_i | input | 1 | Power-up load strobe |
| pwrup_data_i | input | NPOT*WIDTH | Default stored setting of each channel |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | SELW | Channel index for host write |
| host_data_i | input | WIDTH | Host write value |
| xfr_i | input | 1 | Single transfer strobe |
| xfr_sel_i | input | SELW | Channel index for single transfer |
| xfr_data_i | input | WIDTH | Stored register value to transfer |
| gxfr_i | input | 1 | Global transfer strobe |
| gxfr_data_i | input | NPOT*WIDTH | Stored register value for every channel |
| step_i | input | 1 | Step strobe, one per serial clock pulse |
| step_up_i | input | 1 | Step direction, 1 toward the high end |
| step_sel_i | input | SELW | Channel index for stepping |
| wiper_o | output | NPOT*WIDTH | Wiper codes, channel k in slice k |

## Verification
The bench walks each counter into both ends of its range and steps past them. A design that wraps around would show 0x00 after 0xFF, or 0xFF after 0x00. It times the transfer delay edge by edge, so an off-by-one counter shows the new value one cycle too early or too late. It puts a write and a step on the same channel in one cycle, where a wrong priority leaves the written value plus one. It also follows a transfer with a host write to the same channel. A design that forgets to cancel the waiting transfer would overwrite the host value when the delay ends.

// File: rtl/wb_pkg.sv
package wb_pkg;

   // Source that reloads a wiper counter in a given cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PWR  = 2'd1,
      SRC_HOST = 2'd2,
      SRC_XFR  = 2'd3
   } wb_src_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wb_settle.sv
// Per-channel settling timer: holds a transfer value until the response delay runs out.
module wb_settle #(
   parameter int WIDTH       = 8,
   parameter int DELAY_TICKS = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [WIDTH-1:0] arm_data_i,
   input  logic             cancel_i,
   output logic             fire_o,
   output logic [WIDTH-1:0] fire_data_o
);

   generate
      if (DELAY_TICKS < 0) begin : g_bad_delay
         $error("wb_settle: DELAY_TICKS must not be negative");
      end

      if (DELAY_TICKS == 0) begin : g_direct
         logic unused_settle;
         assign unused_settle = cancel_i;
         assign fire_o        = arm_i;
         assign fire_data_o   = arm_data_i;
      end else begin : g_timed
         localparam int CW = $clog2(DELAY_TICKS + 1);
         localparam logic [CW-1:0] LOAD = CW'(DELAY_TICKS);
         localparam logic [CW-1:0] ONE  = CW'(1);

         logic [CW-1:0]    cnt_q;
         logic             pend_q;
         logic [WIDTH-1:0] data_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               pend_q <= 1'b0;
               data_q <= '0;
            end else if (arm_i) begin
               cnt_q  <= LOAD;
               pend_q <= 1'b1;
               data_q <= arm_data_i;
            end else if (cancel_i) begin
               cnt_q  <= '0;
               pend_q <= 1'b0;
            end else if (pend_q) begin
               cnt_q <= cnt_q - ONE;
               if (cnt_q == ONE) begin
                  pend_q <= 1'b0;
               end
            end
         end

         assign fire_o      = pend_q && (cnt_q == ONE);
         assign fire_data_o = data_q;

         AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_o && !arm_i) |=> !fire_o); // R4

         AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (cancel_i && !arm_i) |=> !fire_o); // R9
      end
   endgenerate

endmodule

// File: rtl/wb_wiper.sv
// One wiper counter: prioritised loads plus saturating single-tap steps.
module wb_wiper
   import wb_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_ld_i,
   input  logic [WIDTH-1:0] pwr_data_i,
   input  logic             host_ld_i,
   input  logic [WIDTH-1:0] host_data_i,
   input  logic             xfr_ld_i,
   input  logic [WIDTH-1:0] xfr_data_i,
   input  logic             step_i,
   input  logic             step_up_i,
   output logic [WIDTH-1:0] wiper_o
);

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BOT = '0;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("wb_wiper: WIDTH must be at least 2");
      end
   endgenerate

   wb_src_e          src;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      if (pwr_ld_i)       src = SRC_PWR;
      else if (host_ld_i) src = SRC_HOST;
      else if (xfr_ld_i)  src = SRC_XFR;
      else                src = SRC_NONE;
   end

   always_comb begin
      if (step_up_i) stepped = (q == TOP) ? q : q + ONE;
      else           stepped = (q == BOT) ? q : q - ONE;
   end

   always_comb begin
      case (src)
         SRC_PWR:  nxt = pwr_data_i;
         SRC_HOST: nxt = host_data_i;
         SRC_XFR:  nxt = xfr_data_i;
         default:  nxt = step_i ? stepped : q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   assign wiper_o = q;

   AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ld_i |=> (wiper_o == $past(pwr_data_i))); // R2

   AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ld_i && !pwr_ld_i && step_i) |=> (wiper_o == $past(host_data_i))); // R8

   AST_STEP_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && step_up_i && !pwr_ld_i && !host_ld_i && !xfr_ld_i && wiper_o == TOP)
      |=> (wiper_o == TOP)); // R7

   AST_STEP_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !step_up_i && !pwr_ld_i && !host_ld_i && !xfr_ld_i && wiper_o == BOT)
      |=> (wiper_o == BOT)); // R7

   AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && step_up_i && !pwr_ld_i && !host_ld_i && !xfr_ld_i && wiper_o != TOP)
      |=> (wiper_o == $past(wiper_o) + ONE)); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !pwr_ld_i && !host_ld_i && !xfr_ld_i) |=> $stable(wiper_o)); // R6

endmodule

// File: rtl/wiper_bank.sv
// Bank of wiper counters with host, transfer, power-up and step sources.
module wiper_bank
   import wb_pkg::*;
#(
   parameter int NPOT        = 4,
   parameter int WIDTH       = 8,
   parameter int DELAY_TICKS = 250,
   localparam int SELW       = sel_width(NPOT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwrup_i,
   input  logic [NPOT*WIDTH-1:0] pwrup_data_i,
   input  logic                  host_wr_i,
   input  logic [SELW-1:0]       host_sel_i,
   input  logic [WIDTH-1:0]      host_data_i,
   input  logic                  xfr_i,
   input  logic [SELW-1:0]       xfr_sel_i,
   input  logic [WIDTH-1:0]      xfr_data_i,
   input  logic                  gxfr_i,
   input  logic [NPOT*WIDTH-1:0] gxfr_data_i,
   input  logic                  step_i,
   input  logic                  step_up_i,
   input  logic [SELW-1:0]       step_sel_i,
   output logic [NPOT*WIDTH-1:0] wiper_o
);

   generate
      if (NPOT < 1) begin : g_bad_npot
         $error("wiper_bank: NPOT must be at least 1");
      end
   endgenerate

   logic [NPOT-1:0] step_hit;

   for (genvar k = 0; k < NPOT; k++) begin : g_chan
      logic             host_hit;
      logic             xfr_hit;
      logic             arm;
      logic [WIDTH-1:0] arm_data;
      logic             fire;
      logic [WIDTH-1:0] fire_data;

      assign host_hit    = host_wr_i && (host_sel_i == SELW'(k));
      assign xfr_hit     = xfr_i && (xfr_sel_i == SELW'(k));
      assign step_hit[k] = step_i && (step_sel_i == SELW'(k));
      assign arm         = gxfr_i || xfr_hit;
      assign arm_data    = gxfr_i ? gxfr_data_i[k*WIDTH +: WIDTH] : xfr_data_i;

      wb_settle #(
         .WIDTH       (WIDTH),
         .DELAY_TICKS (DELAY_TICKS)
      ) u_settle (
         .clk         (clk),
         .rst_n       (rst_n),
         .arm_i       (arm),
         .arm_data_i  (arm_data),
         .cancel_i    (pwrup_i || host_hit),
         .fire_o      (fire),
         .fire_data_o (fire_data)
      );

      wb_wiper #(
         .WIDTH       (WIDTH)
      ) u_wiper (
         .clk         (clk),
         .rst_n       (rst_n),
         .pwr_ld_i    (pwrup_i),
         .pwr_data_i  (pwrup_data_i[k*WIDTH +: WIDTH]),
         .host_ld_i   (host_hit),
         .host_data_i (host_data_i),
         .xfr_ld_i    (fire),
         .xfr_data_i  (fire_data),
         .step_i      (step_hit[k]),
         .step_up_i   (step_up_i),
         .wiper_o     (wiper_o[k*WIDTH +: WIDTH])
      );
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || wiper_o == '0)); // R1

   AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_hit)); // R6

endmodule

// File: tb/wiper_bank_bench.sv
module wiper_bank_bench;

   localparam int NPOT  = 4;
   localparam int WIDTH = 8;
   localparam int DLY   = 3;
   localparam int NVEC  = 10;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  pwrup_i = 1'b0;
   logic [NPOT*WIDTH-1:0] pwrup_data_i = '0;
   logic                  host_wr_i = 1'b0;
   logic [1:0]            host_sel_i = '0;
   logic [WIDTH-1:0]      host_data_i = '0;
   logic                  xfr_i = 1'b0;
   logic [1:0]            xfr_sel_i = '0;
   logic [WIDTH-1:0]      xfr_data_i = '0;
   logic                  gxfr_i = 1'b0;
   logic [NPOT*WIDTH-1:0] gxfr_data_i = '0;
   logic                  step_i = 1'b0;
   logic                  step_up_i = 1'b0;
   logic [1:0]            step_sel_i = '0;
   logic [NPOT*WIDTH-1:0] wiper_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wiper_bank #(
      .NPOT        (NPOT),
      .WIDTH       (WIDTH),
      .DELAY_TICKS (DLY)
   ) u_wiper_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwrup_i      (pwrup_i),
      .pwrup_data_i (pwrup_data_i),
      .host_wr_i    (host_wr_i),
      .host_sel_i   (host_sel_i),
      .host_data_i  (host_data_i),
      .xfr_i        (xfr_i),
      .xfr_sel_i    (xfr_sel_i),
      .xfr_data_i   (xfr_data_i),
      .gxfr_i       (gxfr_i),
      .gxfr_data_i  (gxfr_data_i),
      .step_i       (step_i),
      .step_up_i    (step_up_i),
      .step_sel_i   (step_sel_i),
      .wiper_o      (wiper_o)
   );

   // Vector: {op(2) 0=host write 1=step, sel(2), up(1), data(8), expected wipers ch3..ch0 (32)}
   localparam logic [44:0] VEC [NVEC] = '{
      {2'd0, 2'd0, 1'b0, 8'hFE, 32'h403020FE},  // R3 write ch0
      {2'd1, 2'd0, 1'b1, 8'h00, 32'h403020FF},  // R6 step up
      {2'd1, 2'd0, 1'b1, 8'h00, 32'h403020FF},  // R7 hold at top
      {2'd0, 2'd1, 1'b0, 8'h01, 32'h403001FF},  // R3 write ch1
      {2'd1, 2'd1, 1'b0, 8'h00, 32'h403000FF},  // R6 step down
      {2'd1, 2'd1, 1'b0, 8'h00, 32'h403000FF},  // R7 hold at bottom
      {2'd1, 2'd3, 1'b1, 8'h00, 32'h413000FF},  // R6 ch3 up
      {2'd1, 2'd2, 1'b0, 8'h00, 32'h412F00FF},  // R6 ch2 down
      {2'd0, 2'd2, 1'b0, 8'h80, 32'h418000FF},  // R3 write ch2
      {2'd1, 2'd0, 1'b0, 8'h00, 32'h418000FE}   // R6 ch0 down
   };

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic clear_strobes();
      pwrup_i   = 1'b0;
      host_wr_i = 1'b0;
      xfr_i     = 1'b0;
      gxfr_i    = 1'b0;
      step_i    = 1'b0;
   endtask

   task automatic chk(input string req, input logic [NPOT*WIDTH-1:0] exp);
      checks++;
      if (wiper_o !== exp) begin
         errors++;
         $display("FAIL %s wiper actual %h expected %h", req, wiper_o, exp);
      end
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog timeout");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp;

      repeat (3) tick();
      chk("R1", 32'h0);                       // R1 during reset
      rst_n = 1'b1;
      tick();
      tick();
      chk("R1", 32'h0);                       // R1 before power-up load

      pwrup_data_i = 32'h40302010;
      pwrup_i = 1'b1;
      tick();
      clear_strobes();
      chk("R2", 32'h40302010);                // R2

      for (int i = 0; i < NVEC; i++) begin
         logic [44:0] v;
         v = VEC[i];
         if (v[44:43] == 2'd0) begin
            host_wr_i   = 1'b1;
            host_sel_i  = v[42:41];
            host_data_i = v[39:32];
         end else begin
            step_i     = 1'b1;
            step_sel_i = v[42:41];
            step_up_i  = v[40];
         end
         tick();
         clear_strobes();
         chk("R3/R6/R7 table", v[31:0]);
      end

      // R8: write and step on the same channel in one cycle
      host_wr_i = 1'b1; host_sel_i = 2'd0; host_data_i = 8'h55;
      step_i = 1'b1; step_sel_i = 2'd0; step_up_i = 1'b1;
      tick();
      clear_strobes();
      exp = 32'h41800055;
      chk("R8", exp);

      // R4: single transfer timing
      xfr_i = 1'b1; xfr_sel_i = 2'd1; xfr_data_i = 8'hA5;
      for (int k = 0; k < DLY; k++) begin
         tick();
         clear_strobes();
         chk("R4 before delay", exp);
      end
      tick();
      exp = 32'h4180A555;
      chk("R4 after delay", exp);

      // R5: global transfer
      gxfr_i = 1'b1; gxfr_data_i = 32'h04030201;
      for (int k = 0; k < DLY; k++) begin
         tick();
         clear_strobes();
      end
      chk("R5 before delay", exp);
      tick();
      exp = 32'h04030201;
      chk("R5 after delay", exp);

      // R9: host write cancels a waiting transfer
      xfr_i = 1'b1; xfr_sel_i = 2'd2; xfr_data_i = 8'h77;
      tick();
      clear_strobes();
      host_wr_i = 1'b1; host_sel_i = 2'd2; host_data_i = 8'h11;
      tick();
      clear_strobes();
      exp = 32'h04110201;
      chk("R9 write", exp);
      repeat (DLY + 2) tick();
      chk("R9 after delay", exp);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule